// File: doc/BRIEF.md
# Subset RISC Instruction Decoder

This block is a purely combinational decoder for a small subset of a 32-bit load-store instruction set. One instruction word goes in. The block returns the control word that a datapath needs to execute that instruction:

- the two source register addresses;
- the destination register address and its write enable;
- the ALU operand select and ALU operation;
- the immediate extension mode and the extended immediate;
- the data-memory read and write strobes and the access size;
- the control-transfer kind;
- a flag that selects the return-address value as write data.

Register-register instructions are decoded from the primary opcode together with the function code. Immediate, memory, branch and jump instructions are decoded from the primary opcode alone. Any encoding outside the supported set is reported on a dedicated flag. For such an encoding the block suppresses every write and every control transfer, so that a trap handler can take over. The register file, the ALU, the memories and the next-PC logic sit outside the block and consume its outputs.

Top module: `rdec_top`

## Requirements
- R1: `src_a` is always instr[25:21] and `src_b` is always instr[20:16], whatever the instruction.
- R2: With opcode 0, function codes 32, 34 and 42 give alu_op 0 (add), 1 (subtract) and 2 (signed set-less-than). For these, alu_imm=0, dst_addr=instr[15:11] and no memory access or transfer.
- R3: Opcodes 8, 10, 13 and 15 give alu_op 0, 2, 3 (or) and 4 (pass immediate) respectively. They set alu_imm=1 and dst_addr=instr[20:16].
- R4: imm_kind is 0 (sign) for opcodes 8, 10, 32, 35, 40, 43, 4 and 5, is 1 (zero) for opcode 13, and is 2 (upper) for opcode 15. imm_val is then instr[15:0] sign-extended, zero-extended, or placed in bits 31:16 over sixteen zeros.
- R5: Opcodes 35 (word) and 32 (byte) are loads. They give mem_rd=1, alu_op 0, alu_imm=1 and dst_addr=instr[20:16]. mem_byte=1 only for opcode 32.
- R6: Opcodes 43 (word) and 40 (byte) are stores. They give mem_wr=1, alu_op 0, alu_imm=1, dst_addr=0 and reg_we=0. mem_byte=1 only for opcode 40.
- R7: Opcodes 4 and 5 give xfer 1 (branch if equal) and 2 (branch if not equal). They also give alu_op 1, alu_imm=0, dst_addr=0 and reg_we=0.
- R8: Opcode 2 gives xfer 3 (jump to target). Opcode 0 with function code 8 gives xfer 4 (jump to register). Both give dst_addr=0 and reg_we=0.
- R9: Opcode 3 gives xfer 3, link=1, dst_addr=31 and reg_we=1.
- R10: reg_we is 1 only when the instruction writes a register and dst_addr is not 0.
- R11: Any other opcode, or opcode 0 with any other function code, gives bad_op=1. It also gives reg_we=0, mem_rd=0, mem_wr=0, xfer 0, link=0 and dst_addr=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| src_a | output | 5 | First source register address |
| src_b | output | 5 | Second source register address |
| dst_addr | output | 5 | Destination register address (0 when nothing is written) |
| reg_we | output | 1 | Register file write enable |
| alu_imm | output | 1 | ALU second operand is the immediate |
| alu_op | output | 3 | 0 add, 1 sub, 2 signed slt, 3 or, 4 pass immediate |
| imm_kind | output | 2 | 0 sign, 1 zero, 2 upper |
| imm_val | output | 32 | Extended immediate |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| mem_byte | output | 1 | Memory access is one byte wide |
| xfer | output | 3 | 0 none, 1 beq, 2 bne, 3 jump target, 4 jump register |
| link | output | 1 | Write data is the return address |
| bad_op | output | 1 | Unsupported encoding |

## Verification
The bench attacks the places where a decoder most often slips.

- **Extension mode for the or-immediate.** A decoder that sign-extends here returns ones in the upper half whenever bit 15 is set.
- **Destination of the immediate and load forms.** A decoder that takes rd instead of rt writes the wrong register.
- **Register 0 as destination.** A decoder that forgets to gate it still raises a write enable for r0.
- **Stores, branches and jump-register.** If these leak a write, reg_we rises for an instruction that should not write.
- **Illegal encodings.** Random and deliberately illegal opcodes and function codes check that nothing is written, read or transferred.

Every output is compared for each instruction. The stimulus mixes a directed encoding per instruction with seeded random fields, so that immediates with bit 15 both set and clear are covered.

// File: rtl/rdec_pkg.sv
package rdec_pkg;
  localparam int XLEN   = 32;
  localparam int OPW    = 6;
  localparam int RAW    = 5;
  localparam int IMMW   = 16;

  localparam logic [OPW-1:0] OP_RTYPE = 6'd0;
  localparam logic [OPW-1:0] OP_J     = 6'd2;
  localparam logic [OPW-1:0] OP_JAL   = 6'd3;
  localparam logic [OPW-1:0] OP_BEQ   = 6'd4;
  localparam logic [OPW-1:0] OP_BNE   = 6'd5;
  localparam logic [OPW-1:0] OP_ADDI  = 6'd8;
  localparam logic [OPW-1:0] OP_SLTI  = 6'd10;
  localparam logic [OPW-1:0] OP_ORI   = 6'd13;
  localparam logic [OPW-1:0] OP_LUI   = 6'd15;
  localparam logic [OPW-1:0] OP_LB    = 6'd32;
  localparam logic [OPW-1:0] OP_LW    = 6'd35;
  localparam logic [OPW-1:0] OP_SB    = 6'd40;
  localparam logic [OPW-1:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_SLT = 3'd2, ALU_OR = 3'd3, ALU_PASS = 3'd4
  } alu_e;

  typedef enum logic [1:0] {
    IMM_SIGN = 2'd0, IMM_ZERO = 2'd1, IMM_UPPER = 2'd2
  } imm_e;

  typedef enum logic [2:0] {
    XF_NONE = 3'd0, XF_EQ = 3'd1, XF_NE = 3'd2, XF_JUMP = 3'd3, XF_JREG = 3'd4
  } xfer_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_RD = 2'd1, DST_RT = 2'd2, DST_LINK = 2'd3
  } dst_e;

  typedef struct packed {
    logic  legal;
    dst_e  dst;
    logic  alu_imm;
    alu_e  alu;
    imm_e  imm;
    logic  mrd;
    logic  mwr;
    logic  mbyte;
    xfer_e xf;
    logic  link;
  } ctl_t;

  localparam ctl_t CTL_BAD = '{legal: 1'b0, dst: DST_NONE, alu_imm: 1'b0, alu: ALU_ADD,
                               imm: IMM_SIGN, mrd: 1'b0, mwr: 1'b0, mbyte: 1'b0,
                               xf: XF_NONE, link: 1'b0};

  function automatic logic [XLEN-1:0] extend_imm(input logic [IMMW-1:0] v, input imm_e m);
    logic [XLEN-1:0] r;
    case (m)
      IMM_ZERO:  r = {{(XLEN-IMMW){1'b0}}, v};
      IMM_UPPER: r = {v, {(XLEN-IMMW){1'b0}}};
      default:   r = {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rdec_funct.sv
module rdec_funct
  import rdec_pkg::*;
(
  input  logic [5:0] funct,
  output ctl_t       ctl
);
  always_comb begin
    ctl = CTL_BAD;
    case (funct)
      FN_ADD: begin ctl.legal = 1'b1; ctl.dst = DST_RD; ctl.alu = ALU_ADD; end
      FN_SUB: begin ctl.legal = 1'b1; ctl.dst = DST_RD; ctl.alu = ALU_SUB; end
      FN_SLT: begin ctl.legal = 1'b1; ctl.dst = DST_RD; ctl.alu = ALU_SLT; end
      FN_JR:  begin ctl.legal = 1'b1; ctl.xf = XF_JREG; end
      default: ctl = CTL_BAD;
    endcase
  end
endmodule

// File: rtl/rdec_opcode.sv
module rdec_opcode
  import rdec_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  ctl_t           r_ctl,
  output ctl_t           ctl
);
  always_comb begin
    ctl = CTL_BAD;
    case (op)
      OP_RTYPE: ctl = r_ctl;
      OP_ADDI: begin ctl.legal = 1'b1; ctl.dst = DST_RT; ctl.alu_imm = 1'b1; ctl.alu = ALU_ADD; end
      OP_SLTI: begin ctl.legal = 1'b1; ctl.dst = DST_RT; ctl.alu_imm = 1'b1; ctl.alu = ALU_SLT; end
      OP_ORI: begin
        ctl.legal = 1'b1; ctl.dst = DST_RT; ctl.alu_imm = 1'b1; ctl.alu = ALU_OR;
        ctl.imm = IMM_ZERO;
      end
      OP_LUI: begin
        ctl.legal = 1'b1; ctl.dst = DST_RT; ctl.alu_imm = 1'b1; ctl.alu = ALU_PASS;
        ctl.imm = IMM_UPPER;
      end
      OP_LW, OP_LB: begin
        ctl.legal = 1'b1; ctl.dst = DST_RT; ctl.alu_imm = 1'b1; ctl.mrd = 1'b1;
        ctl.mbyte = (op == OP_LB);
      end
      OP_SW, OP_SB: begin
        ctl.legal = 1'b1; ctl.alu_imm = 1'b1; ctl.mwr = 1'b1;
        ctl.mbyte = (op == OP_SB);
      end
      OP_BEQ: begin ctl.legal = 1'b1; ctl.alu = ALU_SUB; ctl.xf = XF_EQ; end
      OP_BNE: begin ctl.legal = 1'b1; ctl.alu = ALU_SUB; ctl.xf = XF_NE; end
      OP_J:   begin ctl.legal = 1'b1; ctl.xf = XF_JUMP; end
      OP_JAL: begin ctl.legal = 1'b1; ctl.xf = XF_JUMP; ctl.dst = DST_LINK; ctl.link = 1'b1; end
      default: ctl = CTL_BAD;
    endcase
  end
endmodule

// File: rtl/rdec_imm.sv
module rdec_imm
  import rdec_pkg::*;
(
  input  logic [IMMW-1:0] raw,
  input  imm_e            mode,
  output logic [XLEN-1:0] value
);
  assign value = extend_imm(raw, mode);
endmodule

// File: rtl/rdec_top.sv
module rdec_top
  import rdec_pkg::*;
#(
  parameter int IW       = 32,
  parameter int AW       = 5,
  parameter int LINK_REG = 31
) (
  input  logic [IW-1:0] instr,
  output logic [AW-1:0] src_a,
  output logic [AW-1:0] src_b,
  output logic [AW-1:0] dst_addr,
  output logic          reg_we,
  output logic          alu_imm,
  output logic [2:0]    alu_op,
  output logic [1:0]    imm_kind,
  output logic [IW-1:0] imm_val,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_byte,
  output logic [2:0]    xfer,
  output logic          link,
  output logic          bad_op
);
  localparam int OP_LSB = IW - OPW;
  localparam int RS_LSB = OP_LSB - AW;
  localparam int RT_LSB = RS_LSB - AW;
  localparam int RD_LSB = RT_LSB - AW;

  logic [OPW-1:0] f_op;
  logic [AW-1:0]  f_rs, f_rt, f_rd;
  logic [5:0]     f_fn;
  logic [IMMW-1:0] f_imm;
  ctl_t           r_ctl, ctl;
  logic           writes_reg;

  assign f_op  = instr[IW-1 -: OPW];
  assign f_rs  = instr[RS_LSB +: AW];
  assign f_rt  = instr[RT_LSB +: AW];
  assign f_rd  = instr[RD_LSB +: AW];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[IMMW-1:0];

  rdec_funct  u_fn  (.funct(f_fn), .ctl(r_ctl));
  rdec_opcode u_op  (.op(f_op), .r_ctl(r_ctl), .ctl(ctl));
  rdec_imm    u_imm (.raw(f_imm), .mode(ctl.imm), .value(imm_val));

  always_comb begin
    case (ctl.dst)
      DST_RD:   dst_addr = f_rd;
      DST_RT:   dst_addr = f_rt;
      DST_LINK: dst_addr = AW'(LINK_REG);
      default:  dst_addr = '0;
    endcase
  end

  assign writes_reg = ctl.legal && (ctl.dst != DST_NONE);
  assign reg_we     = writes_reg && (dst_addr != '0);
  assign src_a      = f_rs;
  assign src_b      = f_rt;
  assign alu_imm    = ctl.alu_imm;
  assign alu_op     = ctl.alu;
  assign imm_kind   = ctl.imm;
  assign mem_rd     = ctl.mrd;
  assign mem_wr     = ctl.mwr;
  assign mem_byte   = ctl.mbyte;
  assign xfer       = ctl.xf;
  assign link       = ctl.link;
  assign bad_op     = !ctl.legal;

  always_comb begin
    // R11
    bad_quiet_chk: assert (!bad_op || (!reg_we && !mem_wr && !mem_rd && xfer == 3'd0));
    // R10
    no_r0_write_chk: assert (!reg_we || dst_addr != '0);
    // R6
    store_no_wb_chk: assert (!mem_wr || (!reg_we && !mem_rd));
    // R9
    link_dst_chk: assert (!link || (dst_addr == AW'(LINK_REG) && reg_we));
    // R4
    zero_ext_chk: assert (imm_kind != 2'd1 || imm_val[IW-1:IMMW] == '0);
  end
endmodule

// File: tb/sim_rdec_top.sv
module sim_rdec_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr;
  logic [4:0]  src_a, src_b, dst_addr;
  logic        reg_we, alu_imm, mem_rd, mem_wr, mem_byte, link, bad_op;
  logic [2:0]  alu_op, xfer;
  logic [1:0]  imm_kind;
  logic [31:0] imm_val;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  rdec_top u0 (.instr, .src_a, .src_b, .dst_addr, .reg_we, .alu_imm, .alu_op,
               .imm_kind, .imm_val, .mem_rd, .mem_wr, .mem_byte, .xfer, .link, .bad_op);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", req, what, instr, act, exp);
    end
  endtask

  function automatic logic [31:0] ext(input logic [15:0] v, input int k);
    if (k == 1) return 32'(v);
    if (k == 2) return 32'(v) << 16;
    return 32'($signed(v));
  endfunction

  task automatic apply(input logic [31:0] w);
    int op, fn, e_alu, e_imm, e_xf, e_dst;
    bit e_aimm, e_rd, e_wr, e_byte, e_link, e_bad, e_wb;
    string tag;
    @(posedge clk); #1 instr = w;
    @(negedge clk);
    op = int'(w[31:26]); fn = int'(w[5:0]);
    e_alu = 0; e_imm = 0; e_xf = 0; e_dst = 0;
    e_aimm = 0; e_rd = 0; e_wr = 0; e_byte = 0; e_link = 0; e_bad = 0; e_wb = 0;
    tag = "R11";
    case (op)
      0: case (fn)
           32: begin tag = "R2"; e_dst = int'(w[15:11]); e_wb = 1; end
           34: begin tag = "R2"; e_dst = int'(w[15:11]); e_wb = 1; e_alu = 1; end
           42: begin tag = "R2"; e_dst = int'(w[15:11]); e_wb = 1; e_alu = 2; end
           8:  begin tag = "R8"; e_xf = 4; end
           default: e_bad = 1;
         endcase
      8:  begin tag = "R3"; e_dst = int'(w[20:16]); e_wb = 1; e_aimm = 1; end
      10: begin tag = "R3"; e_dst = int'(w[20:16]); e_wb = 1; e_aimm = 1; e_alu = 2; end
      13: begin tag = "R4"; e_dst = int'(w[20:16]); e_wb = 1; e_aimm = 1; e_alu = 3; e_imm = 1; end
      15: begin tag = "R4"; e_dst = int'(w[20:16]); e_wb = 1; e_aimm = 1; e_alu = 4; e_imm = 2; end
      35, 32: begin tag = "R5"; e_dst = int'(w[20:16]); e_wb = 1; e_aimm = 1; e_rd = 1; e_byte = (op == 32); end
      43, 40: begin tag = "R6"; e_aimm = 1; e_wr = 1; e_byte = (op == 40); end
      4: begin tag = "R7"; e_alu = 1; e_xf = 1; end
      5: begin tag = "R7"; e_alu = 1; e_xf = 2; end
      2: begin tag = "R8"; e_xf = 3; end
      3: begin tag = "R9"; e_xf = 3; e_dst = 31; e_wb = 1; e_link = 1; end
      default: e_bad = 1;
    endcase
    chk("R1", "src_a", 32'(src_a), 32'(w[25:21]));
    chk("R1", "src_b", 32'(src_b), 32'(w[20:16]));
    chk(tag, "dst_addr", 32'(dst_addr), 32'(e_dst));
    chk(e_dst == 0 ? "R10" : tag, "reg_we", 32'(reg_we), 32'(e_wb && e_dst != 0));
    chk(tag, "alu_imm", 32'(alu_imm), 32'(e_aimm));
    chk(tag, "alu_op", 32'(alu_op), 32'(e_alu));
    chk("R4", "imm_kind", 32'(imm_kind), 32'(e_imm));
    chk("R4", "imm_val", imm_val, ext(w[15:0], e_imm));
    chk(tag, "mem_rd", 32'(mem_rd), 32'(e_rd));
    chk(tag, "mem_wr", 32'(mem_wr), 32'(e_wr));
    chk(tag, "mem_byte", 32'(mem_byte), 32'(e_byte));
    chk(tag, "xfer", 32'(xfer), 32'(e_xf));
    chk(tag, "link", 32'(link), 32'(e_link));
    chk("R11", "bad_op", 32'(bad_op), 32'(e_bad));
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int ops[13] = '{0, 8, 10, 13, 15, 35, 32, 43, 40, 4, 5, 2, 3};
    int fns[5]  = '{32, 34, 42, 8, 0};
    logic [31:0] w;
    void'($urandom(32'd2024));
    instr = '0;
    // directed: one per instruction, r2/r3 sources, r5 or r6 destination
    apply({6'd0, 5'd2, 5'd3, 5'd5, 5'd0, 6'd32});   // R2 add
    apply({6'd0, 5'd2, 5'd3, 5'd5, 5'd0, 6'd34});   // R2 sub
    apply({6'd0, 5'd2, 5'd3, 5'd5, 5'd0, 6'd42});   // R2 slt
    apply({6'd0, 5'd31, 5'd0, 5'd0, 5'd0, 6'd8});   // R8 jr
    apply({6'd8, 5'd2, 5'd6, 16'h8000});            // R3 addi negative
    apply({6'd10, 5'd2, 5'd6, 16'hFFF1});           // R3 slti
    apply({6'd13, 5'd2, 5'd6, 16'hAAAA});           // R4 ori zero-extended
    apply({6'd15, 5'd0, 5'd6, 16'hAAAA});           // R4 lui upper
    apply({6'd35, 5'd2, 5'd6, 16'h0020});           // R5 lw
    apply({6'd32, 5'd2, 5'd6, 16'hFFFC});           // R5 lb
    apply({6'd43, 5'd2, 5'd6, 16'h0030});           // R6 sw
    apply({6'd40, 5'd2, 5'd6, 16'h8001});           // R6 sb
    apply({6'd4, 5'd2, 5'd3, 16'hFFFE});            // R7 beq
    apply({6'd5, 5'd2, 5'd3, 16'h0004});            // R7 bne
    apply({6'd2, 26'h00009C4});                     // R8 j
    apply({6'd3, 26'h00009C4});                     // R9 jal
    apply({6'd0, 5'd2, 5'd3, 5'd0, 5'd0, 6'd32});   // R10 add to r0
    apply({6'd8, 5'd2, 5'd0, 16'h0001});            // R10 addi to r0
    apply({6'd35, 5'd2, 5'd0, 16'h0000});           // R10 lw to r0
    apply({6'd0, 5'd2, 5'd3, 5'd5, 5'd0, 6'd33});   // R11 bad funct
    apply({6'd63, 26'h3FFFFFF});                    // R11 bad opcode
    apply({6'd1, 5'd2, 5'd3, 16'h1234});            // R11 bad opcode
    for (int i = 0; i < 600; i++) begin
      w = $urandom;
      if (i % 3 != 0) w[31:26] = 6'(ops[$urandom % 13]);
      if (w[31:26] == 6'd0 && (i % 2 == 0)) w[5:0] = 6'(fns[$urandom % 5]);
      apply(w);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule